// File: doc/BRIEF.md
# Vector Requantization Datapath

This block converts a vector of signed 32-bit accumulator values into signed 8-bit results, one lane per element, with every lane running the same fixed-point requantization. A lane removes an input offset and scales the value by a signed 32-bit factor into a 64-bit product. It then brings the product back down with a rounding right shift, adds an output offset and saturates the result to a programmable window. All lanes share one set of configuration values, which another block supplies on plain input pins.

Vectors enter and leave through valid/ready handshakes and move through a two-stage pipeline under one global stall. A vector is taken on a cycle where `in_valid` and `in_ready` are both high, and a result is delivered on a cycle where `out_valid` and `out_ready` are both high. `in_ready` is high exactly when the output register is empty or is being drained in that cycle. While `out_ready` is low and a result is waiting, the whole pipeline freezes and the result stays put. The configuration pins must not change while any vector is in flight.

Top module: `vec_requant`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Lane i reads bits [32i+31:32i] of `in_data` and writes bits [8i+7:8i] of `out_data`, and lanes do not affect each other.
- R3: Each lane subtracts the sign-extended `cfg_in_zp` from its input with 32-bit wrap-around, then multiplies the difference by the signed `cfg_mult` into a 64-bit signed product.
- R4: The product is shifted arithmetically right by `cfg_shift` − 1 (range 0..63) and its low 32 bits are kept as a signed value. A shift of 0 skips this step, so shift 0 gives the same result as shift 1.
- R5: When `cfg_dround` is 1, the 32-bit value is incremented if it is non-negative and decremented if it is negative. In either mode it is then shifted arithmetically right by one more bit.
- R6: The sign-extended `cfg_out_zp` is added with 32-bit wrap-around. A value above `cfg_max` becomes `cfg_max`, and then a value below `cfg_min` becomes `cfg_min`, so `cfg_min` wins when the bounds are crossed. The low 8 bits are emitted.
- R7: Every lane uses the same zero-points, multiplier, shift, bounds and rounding flag.
- R8: `in_ready` is low only in a cycle where `out_valid` is high and `out_ready` is low.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged in the next cycle.
- R10: A vector taken in cycle t appears on the output in cycle t+2 when the pipeline is not stalled in cycle t+1. Results leave in the order the vectors entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block takes the input vector this cycle |
| in_data | input | LANES*32 | Signed 32-bit accumulator per lane |
| cfg_in_zp | input | 8 | Signed input zero-point |
| cfg_out_zp | input | 8 | Signed output zero-point |
| cfg_mult | input | 32 | Signed multiplier |
| cfg_shift | input | 6 | Right-shift amount, 0..63 |
| cfg_max | input | 8 | Signed upper bound |
| cfg_min | input | 8 | Signed lower bound |
| cfg_dround | input | 1 | Enables the away-from-zero nudge |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | LANES*8 | Signed 8-bit result per lane |

## Verification
The properties assume the configuration pins hold still while a vector is in the pipeline. They also assume that `in_valid`, once raised, stays high until the vector is taken, since the bound and hold checks compare results against the pins of the current cycle. The stimulus changes the configuration only after the bench has seen every expected result and `out_valid` has dropped. It holds each input vector until the handshake completes. The crossed-bounds case is left out of the window property by its own guard.

// File: rtl/vrq_pkg.sv
package vrq_pkg;
  localparam int unsigned ACC_W   = 32;
  localparam int unsigned RES_W   = 8;
  localparam int unsigned ZP_W    = 8;
  localparam int unsigned SHIFT_W = 6;
  localparam int unsigned PROD_W  = 2 * ACC_W;
  localparam int unsigned NSTAGE  = 2;

  typedef struct packed {
    logic [ZP_W-1:0]    in_zp;
    logic [ZP_W-1:0]    out_zp;
    logic [ACC_W-1:0]   mult;
    logic [SHIFT_W-1:0] shift;
    logic [RES_W-1:0]   hi;
    logic [RES_W-1:0]   lo;
    logic               dround;
  } vrq_cfg_t;
endpackage

// File: rtl/vrq_ctrl.sv
module vrq_ctrl #(
  parameter int unsigned NSTG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic            adv,
  output logic            in_ready,
  output logic            out_valid
);
  logic [NSTG-1:0] vld_q;

  // The whole pipe moves together unless the last stage holds an unaccepted result.
  assign adv       = ~vld_q[NSTG-1] | out_ready;
  assign in_ready  = adv;
  assign out_valid = vld_q[NSTG-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q[0] <= 1'b0;
    else if (adv) vld_q[0] <= in_valid;
  end

  generate
    for (genvar s = 1; s < NSTG; s++) begin : g_stg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q[s] <= 1'b0;
        else if (adv) vld_q[s] <= vld_q[s-1];
      end
    end
  endgenerate
endmodule

// File: rtl/vrq_round.sv
module vrq_round
  import vrq_pkg::*;
(
  input  logic signed [PROD_W-1:0]  prod,
  input  logic        [SHIFT_W-1:0] shift,
  input  logic                      dround,
  output logic signed [ACC_W-1:0]   rounded
);
  logic signed [PROD_W-1:0] pre;
  logic signed [ACC_W-1:0]  narrow;
  logic signed [ACC_W-1:0]  nudged;
  logic [PROD_W-ACC_W-1:0]  unused_pre_hi;

  always_comb begin
    if (shift == '0) pre = prod;
    else             pre = prod >>> (shift - SHIFT_W'(1));
  end

  assign narrow        = pre[ACC_W-1:0];
  assign unused_pre_hi = pre[PROD_W-1:ACC_W];

  always_comb begin
    if (!dround)           nudged = narrow;
    else if (narrow[ACC_W-1]) nudged = narrow - 32'sd1;
    else                   nudged = narrow + 32'sd1;
  end

  assign rounded = nudged >>> 1;
endmodule

// File: rtl/vrq_lane.sv
module vrq_lane
  import vrq_pkg::*;
(
  input  logic             clk,
  input  logic             adv,
  input  logic [ACC_W-1:0] acc,
  input  vrq_cfg_t         cfg,
  output logic [RES_W-1:0] res
);
  logic signed [ACC_W-1:0]  adj;
  logic signed [PROD_W-1:0] prod_d, prod_q;
  logic signed [ACC_W-1:0]  rnd, biased, top, bot, capped, floored;
  logic [ACC_W-RES_W-1:0]   unused_res_hi;

  // Stage 1: offset removal and widening multiply.
  assign adj    = $signed(acc) - $signed({{(ACC_W-ZP_W){cfg.in_zp[ZP_W-1]}}, cfg.in_zp});
  assign prod_d = $signed({{ACC_W{adj[ACC_W-1]}}, adj}) *
                  $signed({{ACC_W{cfg.mult[ACC_W-1]}}, cfg.mult});

  always_ff @(posedge clk) begin
    if (adv) prod_q <= prod_d;
  end

  // Stage 2: rounding shift, output offset, saturation.
  vrq_round u_round (
    .prod    (prod_q),
    .shift   (cfg.shift),
    .dround  (cfg.dround),
    .rounded (rnd)
  );

  assign biased = rnd + $signed({{(ACC_W-ZP_W){cfg.out_zp[ZP_W-1]}}, cfg.out_zp});
  assign top    = $signed({{(ACC_W-RES_W){cfg.hi[RES_W-1]}}, cfg.hi});
  assign bot    = $signed({{(ACC_W-RES_W){cfg.lo[RES_W-1]}}, cfg.lo});

  always_comb begin
    capped  = (biased > top) ? top : biased;
    floored = (capped < bot) ? bot : capped;
  end

  assign unused_res_hi = floored[ACC_W-1:RES_W];

  always_ff @(posedge clk) begin
    if (adv) res <= floored[RES_W-1:0];
  end
endmodule

// File: rtl/vec_requant.sv
module vec_requant
  import vrq_pkg::*;
#(
  parameter int unsigned LANES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*ACC_W-1:0] in_data,
  input  logic [ZP_W-1:0]        cfg_in_zp,
  input  logic [ZP_W-1:0]        cfg_out_zp,
  input  logic [ACC_W-1:0]       cfg_mult,
  input  logic [SHIFT_W-1:0]     cfg_shift,
  input  logic [RES_W-1:0]       cfg_max,
  input  logic [RES_W-1:0]       cfg_min,
  input  logic                   cfg_dround,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*RES_W-1:0] out_data
);
  localparam int unsigned IN_W  = LANES * ACC_W;
  localparam int unsigned OUT_W = LANES * RES_W;

  vrq_cfg_t cfg;
  logic     adv;

  assign cfg = '{in_zp: cfg_in_zp, out_zp: cfg_out_zp, mult: cfg_mult, shift: cfg_shift,
                 hi: cfg_max, lo: cfg_min, dround: cfg_dround};

  vrq_ctrl #(.NSTG(NSTAGE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .adv       (adv),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      vrq_lane u_lane (
        .clk (clk),
        .adv (adv),
        .acc (in_data[i*ACC_W +: ACC_W]),
        .cfg (cfg),
        .res (out_data[i*RES_W +: RES_W])
      );
    end
  endgenerate

  if (IN_W != LANES * ACC_W || OUT_W != LANES * RES_W) begin : g_bad_width
    $error("lane packing width mismatch");
  end
endmodule

// File: rtl/vec_requant_chk.sv
module vec_requant_chk #(
  parameter int unsigned LANES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         cfg_max,
  input logic [7:0]         cfg_min,
  input logic [LANES*8-1:0] out_data
);
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid && in_ready);

  a_r8_ready_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready) && in_ready |=> out_valid);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_win
      a_r6_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ($signed(cfg_min) <= $signed(cfg_max)) |->
          ($signed(out_data[i*8 +: 8]) <= $signed(cfg_max)) &&
          ($signed(out_data[i*8 +: 8]) >= $signed(cfg_min)));
    end
  endgenerate
endmodule

bind vec_requant vec_requant_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .cfg_max   (cfg_max),
  .cfg_min   (cfg_min),
  .out_data  (out_data)
);

// File: tb/vec_requant_test.sv
module vec_requant_test;
  localparam int L = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [L*32-1:0] in_data = '0;
  logic [L*8-1:0]  out_data;
  logic [7:0]  in_zp = 0, out_zp = 0, cmax = 8'sd127, cmin = -8'sd128;
  logic [31:0] mult = 1;
  logic [5:0]  shift = 1;
  logic        dround = 0;

  int checks = 0, fails = 0, cycles = 0;
  logic [L*8-1:0] expq[$];
  logic [L*8-1:0] last_out;
  bit stall_mode = 0;

  vec_requant #(.LANES(L)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cfg_in_zp(in_zp), .cfg_out_zp(out_zp), .cfg_mult(mult), .cfg_shift(shift),
    .cfg_max(cmax), .cfg_min(cmin), .cfg_dround(dround),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #5 clk = ~clk;

  function automatic logic [7:0] ref_lane(input logic [31:0] x);
    int a, v;
    longint p, pre;
    a = int'(x) - int'($signed(in_zp));
    p = longint'(a) * longint'($signed(mult));
    pre = (shift == 0) ? p : (p >>> (shift - 1));
    v = int'(pre);
    if (dround) v = (v >= 0) ? v + 1 : v - 1;
    v = v >>> 1;
    v = v + int'($signed(out_zp));
    if (v > int'($signed(cmax))) v = int'($signed(cmax));
    if (v < int'($signed(cmin))) v = int'($signed(cmin));
    return v[7:0];
  endfunction

  function automatic logic [L*8-1:0] ref_vec(input logic [L*32-1:0] d);
    logic [L*8-1:0] r;
    for (int i = 0; i < L; i++) r[i*8 +: 8] = ref_lane(d[i*32 +: 32]);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [L*8-1:0] act, input logic [L*8-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: sample fires between edges, then land on the next falling edge.
  task automatic tick(output bit took);
    bit stalled;
    logic [L*8-1:0] held;
    #1;
    took = in_valid && in_ready;
    stalled = out_valid && !out_ready;
    held = out_data;
    // R8: input is refused only when a result is stuck at the output
    if (!in_ready) check(out_valid && !out_ready, "R8 ready", {L*8{in_ready}}, '0);
    if (out_valid && out_ready) begin
      last_out = out_data;
      if (expq.size() == 0) check(0, "R10 unexpected output", out_data, '0);
      else begin
        logic [L*8-1:0] e;
        e = expq.pop_front();
        // R2 R3 R4 R5 R6 R7 R10: lane values and order
        check(out_data == e, "R2 R3 R4 R5 R6 R7 R10 data", out_data, e);
      end
    end
    if (took) expq.push_back(ref_vec(in_data));
    @(negedge clk);
    // R9: a stalled result holds
    if (stalled) check(out_valid && out_data == held, "R9 hold", out_data, held);
  endtask

  task automatic send(input logic [L*32-1:0] v);
    bit took;
    in_data = v;
    in_valid = 1;
    do begin
      out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
      tick(took);
    end while (!took);
    in_valid = 0;
  endtask

  task automatic drain();
    bit took;
    out_ready = 1;
    while (expq.size() != 0 || out_valid) begin
      out_ready = stall_mode ? ($urandom % 2 == 0) : 1'b1;
      tick(took);
    end
    out_ready = 0;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 7)
      0: return 32'h0;
      1: return 32'hffffffff;
      2: return 32'h7fffffff;
      3: return 32'h80000000;
      4: return $urandom % 2000 - 1000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [L*32-1:0] rand_vec();
    logic [L*32-1:0] v;
    for (int i = 0; i < L; i++) v[i*32 +: 32] = pick();
    return v;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL R10 watchdog actual=%0d expected<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] mults[4];
    logic [L*8-1:0] o0, o1;
    logic [L*32-1:0] v;
    bit took;
    mults = '{32'h7fffffff, 32'h80000000, 32'h40000000, 32'h00012345};
    repeat (3) @(negedge clk);
    // R1: idle after reset
    check(!out_valid && in_ready, "R1 reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {out_valid, in_ready}, 2'b01);

    // R10: latency of two cycles with no stall
    mult = 32'd3; shift = 6'd1;
    send({32'd4, 32'd3, 32'd2, 32'd1});
    check(!out_valid, "R10 not yet", {L*8{out_valid}}, '0);
    out_ready = 1;
    tick(took);
    check(out_valid, "R10 latency", {L*8{out_valid}}, '1);
    drain();

    // R2 R7: distinct lane values, identity scaling, lane mapping
    mult = 32'd2; shift = 6'd1;
    send({32'd10, -32'sd7, 32'd0, 32'd60});
    drain();
    check(last_out == {8'd10, -8'sd7, 8'd0, 8'd60}, "R2 lane map", last_out, {8'd10, -8'sd7, 8'd0, 8'd60});

    // R4: shift 0 equals shift 1
    v = {32'd1001, -32'sd999, 32'd77, -32'sd5};
    mult = 32'd12345; dround = 1; shift = 6'd0;
    send(v); drain(); o0 = last_out;
    shift = 6'd1;
    send(v); drain(); o1 = last_out;
    check(o0 == o1, "R4 shift0 vs shift1", o0, o1);

    // R6: crossed bounds give cmin
    cmax = -8'sd10; cmin = 8'sd10; dround = 0; mult = 1;
    send({32'd0, 32'd100, -32'sd100, 32'd20}); drain();
    check(last_out == {4{8'd10}}, "R6 crossed bounds", last_out, {4{8'd10}});

    // Sweep: every shift, both rounding modes, several multipliers, offsets and windows
    stall_mode = 1;
    for (int s = 0; s < 64; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int m = 0; m < 4; m++) begin
          shift = s[5:0]; dround = d[0]; mult = (m == 3) ? $urandom : mults[m];
          in_zp = $urandom; out_zp = $urandom;
          case ((s + m) % 3)
            0: begin cmax = 8'sd127; cmin = -8'sd128; end
            1: begin cmax = 8'sd50;  cmin = -8'sd20;  end
            default: begin cmax = -8'sd5; cmin = 8'sd5; end
          endcase
          for (int k = 0; k < 3; k++) send(rand_vec());
          drain();
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule